// File: doc/BRIEF.md
# Multi-target interrupt router

This block gathers 64 interrupt sources and presents them to four processor targets. Three are application cores and one is a control core. The sources come in two groups of 32. The common group carries sources that older hardware also had. The extended group carries sources that only newer hardware has. A rising edge on any source latches that bit into a private flag bank for every target. Each target masks its own flags, so every target decides for itself which sources it services and when it acknowledges them.

Software reaches the banks over a simple word-addressed register bus. Writes take one cycle and reads are combinational. A flag is acknowledged by writing a one to its bit. Masks are plain read/write storage. The control core has a second mask pair that drives a fast-interrupt line. A small compatibility window at low offsets mirrors the common-group registers of application core 0 and of the control core, so that older driver code keeps working.

Top module: `irq_router`

## Requirements
- R1: While reset is asserted, and right after it is released, every interrupt output is low and every flag, mask and fast mask reads as zero.
- R2: A rising edge on `src_common[i]` sets bit i of the common flag register in all four targets. A rising edge on `src_ext[i]` sets bit i of the extended flag register in all four targets. A source that stays high sets the flag only once, so a cleared flag stays clear until the next rising edge.
- R3: Writing a word to a flag register clears the bits where the word holds 1 and leaves the bits where it holds 0. The clear affects only the addressed target's bank.
- R4: When a rising edge and a write-one-to-clear hit the same flag bit on the same clock edge, the bit ends up set.
- R5: Mask and fast-mask registers store the written word and read it back unchanged. They change only on a bus write to their address.
- R6: A target's interrupt output is high exactly one clock after any bit of (flag AND mask) is set in either group. It goes low one clock after no such bit remains.
- R7: `ctl_fiq` follows the same rule as R6, applied to the control core's flags and its fast masks.
- R8: Byte offsets. Application core k uses 0x440+0x10*k and the control core uses 0x470. Within each bank, +0x0 is the common flag, +0x4 the extended flag, +0x8 the common mask and +0xC the extended mask. The fast masks are at 0x480 (common) and 0x484 (extended).
- R9: The compatibility window aliases existing storage. 0x030 is the common flag of application core 0 and 0x034 its common mask. 0x038 is the control core's common flag and 0x03C its common mask. 0x040 is the control core's common fast mask. Reads and writes through an alias behave exactly like access at the primary address.
- R10: Reads of any other offset return zero, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_common | input | GRP_W (32) | Common-group interrupt sources |
| src_ext | input | GRP_W (32) | Extended-group interrupt sources |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wdata | input | GRP_W (32) | Register write data |
| bus_rdata | output | GRP_W (32) | Register read data for `bus_addr` |
| app_irq | output | NUM_APP (3) | Interrupt line per application core |
| ctl_irq | output | 1 | Control core interrupt line |
| ctl_fiq | output | 1 | Control core fast-interrupt line |

## Verification
The bench builds the router with its defaults: three application cores, 32-bit groups and a 12-bit offset. With these values the whole register map (banks, fast masks, compatibility window and unmapped holes) sits at the exact offsets that software uses, so each address can be written and read back. Four targets are enough to show that one target's acknowledge leaves the other three untouched. They also bring the set-beats-clear collision and the one-cycle output latency within reach, on both the bank outputs and the fast line.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned NUM_GRP     = 2;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned BANK_STRIDE = 16;
  localparam int unsigned SLOTS       = 4;

  localparam int unsigned LEG_APP_FLAG = 0;
  localparam int unsigned LEG_APP_MASK = 4;
  localparam int unsigned LEG_CTL_FLAG = 8;
  localparam int unsigned LEG_CTL_MASK = 12;
  localparam int unsigned LEG_CTL_FIQ  = 16;

  typedef struct packed {
    logic [NUM_GRP-1:0] clr;
    logic [NUM_GRP-1:0] msk;
  } bank_we_t;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = src;
    rise   = src & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank
  import irq_router_pkg::*;
#(
  parameter int unsigned GRP_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_GRP-1:0][GRP_W-1:0]   set_i,
  input  bank_we_t                        we_i,
  input  logic [GRP_W-1:0]                wdata_i,
  output logic [NUM_GRP-1:0][GRP_W-1:0]   flag_o,
  output logic [NUM_GRP-1:0][GRP_W-1:0]   mask_o,
  output logic                            irq_o
);
  logic [NUM_GRP-1:0][GRP_W-1:0] flag_q, flag_d, mask_q, mask_d;
  logic                          irq_q, irq_d;

  always_comb begin
    for (int g = 0; g < int'(NUM_GRP); g++) begin
      flag_d[g] = (flag_q[g] & ~(we_i.clr[g] ? wdata_i : '0)) | set_i[g];
      mask_d[g] = we_i.msk[g] ? wdata_i : mask_q[g];
    end
    irq_d = |(flag_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (|we_i.msk) mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_fiq_unit.sv
module irq_fiq_unit
  import irq_router_pkg::*;
#(
  parameter int unsigned GRP_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_GRP-1:0][GRP_W-1:0] flag_i,
  input  logic [NUM_GRP-1:0]            we_i,
  input  logic [GRP_W-1:0]              wdata_i,
  output logic [NUM_GRP-1:0][GRP_W-1:0] fmask_o,
  output logic                          fiq_o
);
  logic [NUM_GRP-1:0][GRP_W-1:0] fmask_q, fmask_d;
  logic                          fiq_q, fiq_d;

  always_comb begin
    for (int g = 0; g < int'(NUM_GRP); g++)
      fmask_d[g] = we_i[g] ? wdata_i : fmask_q[g];
    fiq_d = |(flag_i & fmask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmask_q <= '0;
      fiq_q   <= 1'b0;
    end else begin
      if (|we_i) fmask_q <= fmask_d;
      fiq_q <= fiq_d;
    end
  end

  assign fmask_o = fmask_q;
  assign fiq_o   = fiq_q;
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned NT          = 4,
  parameter int unsigned GRP_W       = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BANK_BASE   = 'h440,
  parameter int unsigned LEGACY_BASE = 'h030
) (
  input  logic                                    bus_we,
  input  logic [ADDR_W-1:0]                       bus_addr,
  input  logic [NT-1:0][NUM_GRP-1:0][GRP_W-1:0]   flag_i,
  input  logic [NT-1:0][NUM_GRP-1:0][GRP_W-1:0]   mask_i,
  input  logic [NUM_GRP-1:0][GRP_W-1:0]           fmask_i,
  output bank_we_t [NT-1:0]                       bank_we_o,
  output logic [NUM_GRP-1:0]                      fiq_we_o,
  output logic [GRP_W-1:0]                        rdata_o
);
  localparam int unsigned CTL      = NT - 1;
  localparam int unsigned FIQ_BASE = BANK_BASE + NT * BANK_STRIDE;

  always_comb begin
    bank_we_o = '0;
    fiq_we_o  = '0;
    rdata_o   = '0;
    for (int t = 0; t < int'(NT); t++) begin
      for (int s = 0; s < int'(SLOTS); s++) begin
        if (bus_addr == ADDR_W'(BANK_BASE + t * BANK_STRIDE + s * WORD_BYTES)) begin
          if (s >= 2) begin
            rdata_o = mask_i[t][s - 2];
            bank_we_o[t].msk[s - 2] = bus_we;
          end else begin
            rdata_o = flag_i[t][s];
            bank_we_o[t].clr[s] = bus_we;
          end
        end
      end
    end
    for (int g = 0; g < int'(NUM_GRP); g++) begin
      if (bus_addr == ADDR_W'(FIQ_BASE + g * WORD_BYTES)) begin
        rdata_o     = fmask_i[g];
        fiq_we_o[g] = bus_we;
      end
    end
    if (bus_addr == ADDR_W'(LEGACY_BASE + LEG_APP_FLAG)) begin
      rdata_o = flag_i[0][0];
      bank_we_o[0].clr[0] = bus_we;
    end
    if (bus_addr == ADDR_W'(LEGACY_BASE + LEG_APP_MASK)) begin
      rdata_o = mask_i[0][0];
      bank_we_o[0].msk[0] = bus_we;
    end
    if (bus_addr == ADDR_W'(LEGACY_BASE + LEG_CTL_FLAG)) begin
      rdata_o = flag_i[CTL][0];
      bank_we_o[CTL].clr[0] = bus_we;
    end
    if (bus_addr == ADDR_W'(LEGACY_BASE + LEG_CTL_MASK)) begin
      rdata_o = mask_i[CTL][0];
      bank_we_o[CTL].msk[0] = bus_we;
    end
    if (bus_addr == ADDR_W'(LEGACY_BASE + LEG_CTL_FIQ)) begin
      rdata_o     = fmask_i[0];
      fiq_we_o[0] = bus_we;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_APP     = 3,
  parameter int unsigned GRP_W       = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BANK_BASE   = 'h440,
  parameter int unsigned LEGACY_BASE = 'h030
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GRP_W-1:0]   src_common,
  input  logic [GRP_W-1:0]   src_ext,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [GRP_W-1:0]   bus_wdata,
  output logic [GRP_W-1:0]   bus_rdata,
  output logic [NUM_APP-1:0] app_irq,
  output logic               ctl_irq,
  output logic               ctl_fiq
);
  localparam int unsigned NT  = NUM_APP + 1;
  localparam int unsigned CTL = NT - 1;

  logic [NUM_GRP*GRP_W-1:0]              rise;
  logic [NUM_GRP-1:0][GRP_W-1:0]         set_vec;
  logic [NT-1:0][NUM_GRP-1:0][GRP_W-1:0] flag_all, mask_all;
  logic [NUM_GRP-1:0][GRP_W-1:0]         fiqm;
  bank_we_t [NT-1:0]                     bank_we;
  logic [NUM_GRP-1:0]                    fiq_we;
  logic [NT-1:0]                         irq_vec;

  irq_edge_detect #(.W(NUM_GRP * GRP_W)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .src  ({src_ext, src_common}),
    .rise (rise)
  );

  assign set_vec = rise;

  for (genvar t = 0; t < NT; t++) begin : g_bank
    irq_target_bank #(.GRP_W(GRP_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .we_i   (bank_we[t]),
      .wdata_i(bus_wdata),
      .flag_o (flag_all[t]),
      .mask_o (mask_all[t]),
      .irq_o  (irq_vec[t])
    );
  end

  irq_fiq_unit #(.GRP_W(GRP_W)) u_fiq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_i (flag_all[CTL]),
    .we_i   (fiq_we),
    .wdata_i(bus_wdata),
    .fmask_o(fiqm),
    .fiq_o  (ctl_fiq)
  );

  irq_reg_decode #(
    .NT(NT), .GRP_W(GRP_W), .ADDR_W(ADDR_W),
    .BANK_BASE(BANK_BASE), .LEGACY_BASE(LEGACY_BASE)
  ) u_dec (
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .flag_i   (flag_all),
    .mask_i   (mask_all),
    .fmask_i  (fiqm),
    .bank_we_o(bank_we),
    .fiq_we_o (fiq_we),
    .rdata_o  (bus_rdata)
  );

  assign app_irq = irq_vec[NUM_APP-1:0];
  assign ctl_irq = irq_vec[CTL];
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_APP     = 3,
  parameter int unsigned GRP_W       = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BANK_BASE   = 'h440,
  parameter int unsigned LEGACY_BASE = 'h030
) (
  input logic                                            clk,
  input logic                                            rst_n,
  input logic [GRP_W-1:0]                                src_common,
  input logic                                            bus_we,
  input logic [ADDR_W-1:0]                               bus_addr,
  input logic [GRP_W-1:0]                                bus_wdata,
  input logic [NUM_APP-1:0]                              app_irq,
  input logic                                            ctl_irq,
  input logic                                            ctl_fiq,
  input logic [NUM_APP:0][NUM_GRP-1:0][GRP_W-1:0]        flag_all,
  input logic [NUM_APP:0][NUM_GRP-1:0][GRP_W-1:0]        mask_all,
  input logic [NUM_GRP-1:0][GRP_W-1:0]                   fiqm
);
  localparam int unsigned CTL = NUM_APP;

  logic [NUM_APP:0] bit0_all;
  for (genvar t = 0; t <= NUM_APP; t++) begin : g_b0
    assign bit0_all[t] = flag_all[t][0][0];
  end

  logic clr0_wr;
  assign clr0_wr = bus_we && bus_wdata[0] &&
                   (bus_addr == ADDR_W'(BANK_BASE) || bus_addr == ADDR_W'(LEGACY_BASE));

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (app_irq == '0 && !ctl_irq && !ctl_fiq); // R1
    end
  end

  AST_EDGE_SETS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_common[0]) |=> (&bit0_all)); // R2

  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_all[0][0][0]) |-> $past(clr0_wr)); // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(src_common[0]) && clr0_wr) |=> flag_all[0][0][0]); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(mask_all) && $stable(fiqm))); // R5

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (app_irq[0] == $past(|(flag_all[0] & mask_all[0])))); // R6

  AST_FIQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ctl_fiq == $past(|(flag_all[CTL] & fiqm)))); // R7
endmodule

bind irq_router irq_router_checker #(
  .NUM_APP(NUM_APP), .GRP_W(GRP_W), .ADDR_W(ADDR_W),
  .BANK_BASE(BANK_BASE), .LEGACY_BASE(LEGACY_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_common(src_common),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .app_irq   (app_irq),
  .ctl_irq   (ctl_irq),
  .ctl_fiq   (ctl_fiq),
  .flag_all  (flag_all),
  .mask_all  (mask_all),
  .fiqm      (fiqm)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {12'h448, 32'hA5A5_0001}, {12'h44C, 32'h0000_FF02},
    {12'h458, 32'h1234_5603}, {12'h45C, 32'h8000_0004},
    {12'h468, 32'h0F0F_0F05}, {12'h46C, 32'h7777_0006},
    {12'h478, 32'hC3C3_0007}, {12'h47C, 32'h0101_0108},
    {12'h480, 32'hDEAD_0009}, {12'h484, 32'hBEEF_000A}
  };

  logic        clk, rst_n, bus_we, ctl_irq, ctl_fiq;
  logic [31:0] src_common, src_ext, bus_wdata, bus_rdata;
  logic [11:0] bus_addr;
  logic [2:0]  app_irq;
  int checks, failures;

  irq_router u_irq_router (
    .clk(clk), .rst_n(rst_n), .src_common(src_common), .src_ext(src_ext),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .app_irq(app_irq), .ctl_irq(ctl_irq), .ctl_fiq(ctl_fiq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic outs(input logic [4:0] exp, input string req);
    chk(req, {27'd0, app_irq, ctl_irq, ctl_fiq}, {27'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    src_common = '0; src_ext = '0;
    repeat (3) @(negedge clk);
    outs(5'b0, "R1 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    outs(5'b0, "R1 outputs after reset");
    rd(12'h440, 32'h0, "R1 flag reset");
    rd(12'h478, 32'h0, "R1 mask reset");
    rd(12'h484, 32'h0, "R1 fast mask reset");

    // R5 / R8: table walk of every mask register
    for (int i = 0; i < NV; i++) wr(VEC[i][43:32], VEC[i][31:0]);
    for (int i = 0; i < NV; i++) rd(VEC[i][43:32], VEC[i][31:0], "R5 R8 mask readback");
    rd(12'h034, VEC[0][31:0], "R9 alias app0 mask");
    rd(12'h03C, VEC[6][31:0], "R9 alias ctl mask");
    rd(12'h040, VEC[8][31:0], "R9 alias ctl fast mask");
    for (int i = 0; i < NV; i++) wr(VEC[i][43:32], 32'h0);

    // R2: common edge reaches all four banks
    @(negedge clk);
    src_common[3] = 1'b1;
    @(negedge clk);
    rd(12'h440, 32'h8, "R2 app0 flag");
    rd(12'h450, 32'h8, "R2 app1 flag");
    rd(12'h460, 32'h8, "R2 app2 flag");
    rd(12'h470, 32'h8, "R2 ctl flag");
    @(negedge clk);
    outs(5'b0, "R6 masked flag no irq");

    // R6: latency of mask enable
    wr(12'h458, 32'h8);
    outs(5'b0, "R6 one cycle latency");
    @(negedge clk);
    outs(5'b01000, "R6 app1 irq");

    // R3: write-zero keeps, write-one clears only this bank
    wr(12'h450, 32'h0);
    rd(12'h450, 32'h8, "R3 write zero keeps");
    wr(12'h450, 32'h8);
    rd(12'h450, 32'h0, "R3 write one clears");
    rd(12'h440, 32'h8, "R3 other bank untouched");
    @(negedge clk);
    outs(5'b0, "R6 irq drops after clear");
    rd(12'h450, 32'h0, "R2 held level no reset of flag");

    // R7: extended group and fast line
    src_ext[5] = 1'b1;
    @(negedge clk);
    rd(12'h474, 32'h20, "R2 ext flag");
    wr(12'h47C, 32'h20);
    @(negedge clk);
    outs(5'b00010, "R6 ctl irq via ext mask");
    wr(12'h484, 32'h20);
    @(negedge clk);
    outs(5'b00011, "R7 ctl fiq");
    wr(12'h474, 32'h20);
    @(negedge clk);
    outs(5'b0, "R7 fiq and irq drop");

    // R4: set and clear on the same edge
    src_common[3] = 1'b0;
    @(negedge clk);
    src_common[3] = 1'b1;
    bus_we = 1'b1; bus_addr = 12'h440; bus_wdata = 32'h8;
    @(negedge clk);
    bus_we = 1'b0;
    rd(12'h440, 32'h8, "R4 set beats clear");
    rd(12'h450, 32'h8, "R2 new edge sets app1");

    // R9: compatibility window
    wr(12'h038, 32'h8);
    rd(12'h470, 32'h0, "R9 alias clears ctl flag");
    rd(12'h030, 32'h8, "R9 alias reads app0 flag");
    wr(12'h034, 32'h8);
    rd(12'h448, 32'h8, "R9 alias writes app0 mask");
    @(negedge clk);
    outs(5'b01100, "R9 R6 app0 and app1 irq");
    wr(12'h040, 32'h1);
    rd(12'h480, 32'h1, "R9 alias writes fast mask");
    wr(12'h03C, 32'hF0);
    rd(12'h478, 32'hF0, "R9 alias writes ctl mask");

    // R10: unmapped offsets
    rd(12'h500, 32'h0, "R10 unmapped read");
    rd(12'h488, 32'h0, "R10 unmapped read after fast");
    rd(12'h044, 32'h0, "R10 unmapped read after window");
    wr(12'h488, 32'hFFFF_FFFF);
    wr(12'h048, 32'hFFFF_FFFF);
    rd(12'h448, 32'h8, "R10 app0 mask unchanged");
    rd(12'h480, 32'h1, "R10 fast mask unchanged");
    @(negedge clk);
    outs(5'b01100, "R10 outputs unchanged");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule